// File: doc/BRIEF.md
# Glitch-free system clock source selector with power-of-two divider

This block produces the system clock from one of three free-running clock inputs: an internal 16 MHz oscillator, a PLL output and an external clock pin. When software asks for another source, the block hands the output over without a glitch. The old source is gated off on its own falling edge through a two-flop synchronizer. The new source is gated on only after a two-flop synchronizer in its own domain has seen that the old one is off. The output stays low between the two.

The selected clock then passes through a divider that divides it by 2^n, where n is a 3-bit code. A new code is applied only at the end of a full divided period.

A small register file on a separate bus clock holds three things: the source code, the divide code, and a 3-bit divide code for the analog clock, which is stored and driven out only. A status register shows a busy flag while a source change is in progress.

Top module: `sysclk_switch`

## Requirements
- R1: After reset, the word at offset 0 reads 0x0041, the word at offset 1 reads 0x0200, the word at offset 2 reads 0x0000, and `clk_o` follows the PLL input undivided.
- R2: Bits [1:0] of offset 0 select the source: code 00 selects the oscillator, 01 the PLL and 10 the external pin. With divide code 0, the period of `clk_o` equals the period of the selected input.
- R3: Bits [2:0] of offset 1 hold a code n. The period of `clk_o` is 2^n times the period of the source, for n from 0 to 7, and the code changes only at a boundary of the divided period.
- R4: At most one source is gated onto the output at any time, so every high and low pulse on `clk_o` lasts at least half the shortest source period, including pulses during source changes and divide changes.
- R5: Bit 0 of offset 2 (busy) reads 1 from the write of a different valid source code until the new source drives the output, and then returns to 0.
- R6: Writing the source code that is already selected starts no switch: busy stays 0 and the output period does not change.
- R7: A source-code write while busy is 1, or a write of the reserved code 11, leaves bits [1:0] of offset 0 unchanged.
- R8: Bits [10:8] of offset 1 hold the analog divide code, which resets to 010, reads back and drives `adiv_code_o`. Other bits of offset 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_clk_i | input | 1 | Internal oscillator clock |
| pll_clk_i | input | 1 | PLL output clock |
| ext_clk_i | input | 1 | External pin clock |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| clk_o | output | 1 | Divided system clock |
| adiv_code_o | output | 3 | Analog clock divide code |

## Verification
The assertions assume that all three source clocks keep running throughout: the old and the new source each supply the few edges their synchronizers need during a switch. They also assume the bus clock is fast enough to sample the enable vector between source edges. The bench keeps every source toggling from time zero to the end. It writes a new source only after the previous switch has had microseconds to finish, except for the one write that is deliberately placed while busy is 1. The divider assertion assumes the divide code is quasi-static across its synchronizer, so the bench changes it only after several divided periods.

// File: rtl/sysclk_switch_pkg.sv
`timescale 1ns/1ps
package sysclk_switch_pkg;
  localparam int DATA_W   = 16;
  localparam int SEL_W    = 2;
  localparam int DIV_W    = 3;
  localparam int ADIV_LSB = 8;
  localparam int N_SRC    = 3;

  localparam logic [SEL_W-1:0] SRC_OSC  = 2'd0;
  localparam logic [SEL_W-1:0] SRC_PLL  = 2'd1;
  localparam logic [SEL_W-1:0] SRC_EXT  = 2'd2;
  localparam logic [SEL_W-1:0] SRC_RSVD = 2'd3;

  localparam logic [1:0] ADDR_MISC = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam logic [DATA_W-1:0] MISC_RST = 16'h0041;
  localparam logic [DATA_W-1:0] DIV_RST  = 16'h0200;
endpackage

// File: rtl/sysclk_switch_regs.sv
`timescale 1ns/1ps
module sysclk_switch_regs
  import sysclk_switch_pkg::*;
#(
  parameter int N = N_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N-1:0]      en_i,
  output logic [N-1:0]      want_o,
  output logic [DIV_W-1:0]  div_code_o,
  output logic [DIV_W-1:0]  adiv_code_o
);
  logic [DATA_W-1:SEL_W] misc_hi_q;
  logic [SEL_W-1:0]      sel_q;
  logic [DIV_W-1:0]      div_q, adiv_q;
  logic                  busy_q;
  logic [N-1:0]          en_s1_q, en_s2_q;
  logic                  wr_misc, wr_div, sw_req, sw_done;
  logic [SEL_W-1:0]      new_sel;

  always_comb begin
    for (int i = 0; i < N; i++) want_o[i] = (sel_q == SEL_W'(i));
  end

  assign new_sel = wdata_i[SEL_W-1:0];
  assign wr_misc = we_i && (addr_i == ADDR_MISC);
  assign wr_div  = we_i && (addr_i == ADDR_DIV);
  assign sw_req  = wr_misc && !busy_q && (new_sel != SRC_RSVD) && (new_sel != sel_q);
  assign sw_done = busy_q && |(en_s2_q & want_o);

  // enable vector crosses back from the source domains
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_s1_q <= '0;
      en_s2_q <= '0;
    end else begin
      en_s1_q <= en_i;
      en_s2_q <= en_s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      misc_hi_q <= MISC_RST[DATA_W-1:SEL_W];
      sel_q     <= MISC_RST[SEL_W-1:0];
      busy_q    <= 1'b0;
    end else begin
      if (wr_misc) misc_hi_q <= wdata_i[DATA_W-1:SEL_W];
      if (sw_req) begin
        sel_q  <= new_sel;
        busy_q <= 1'b1;
      end else if (sw_done) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= DIV_RST[DIV_W-1:0];
      adiv_q <= DIV_RST[ADIV_LSB+DIV_W-1:ADIV_LSB];
    end else if (wr_div) begin
      div_q  <= wdata_i[DIV_W-1:0];
      adiv_q <= wdata_i[ADIV_LSB+DIV_W-1:ADIV_LSB];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_MISC: rdata_o = {misc_hi_q, sel_q};
      ADDR_DIV: begin
        rdata_o[DIV_W-1:0]                 = div_q;
        rdata_o[ADIV_LSB+DIV_W-1:ADIV_LSB] = adiv_q;
      end
      ADDR_STAT: rdata_o[0] = busy_q;
      default:   rdata_o = '0;
    endcase
  end

  assign div_code_o  = div_q;
  assign adiv_code_o = adiv_q;

  a_r5_busy_on_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_misc && !busy_q && new_sel != SRC_RSVD && new_sel != sel_q) |=> busy_q);

  a_r6_same_code_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_misc && !busy_q && new_sel == sel_q) |=> (!busy_q && $stable(sel_q)));

  a_r7_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_misc && busy_q) |=> $stable(sel_q));

  a_r7_reserved_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_misc && new_sel == SRC_RSVD) |=> $stable(sel_q));
endmodule

// File: rtl/sysclk_switch_src_cell.sv
`timescale 1ns/1ps
module sysclk_switch_src_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic others_en_i,
  output logic en_o,
  output logic gclk_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  // falling-edge chain: enable only changes while the source is low
  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], want_i & ~others_en_i};
  end

  assign en_o   = sync_q[SYNC_STAGES-1];
  assign gclk_o = src_clk_i & en_o;
endmodule

// File: rtl/sysclk_switch_mux.sv
`timescale 1ns/1ps
module sysclk_switch_mux #(
  parameter int N           = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic [N-1:0] src_clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] want_i,
  output logic [N-1:0] en_o,
  output logic         clk_o
);
  logic [N-1:0] gclk;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic others;
    assign others = |(en_o & ~(N'(1) << g));
    sysclk_switch_src_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .src_clk_i  (src_clk_i[g]),
      .rst_ni     (rst_ni),
      .want_i     (want_i[g]),
      .others_en_i(others),
      .en_o       (en_o[g]),
      .gclk_o     (gclk[g])
    );
  end

  assign clk_o = |gclk;
endmodule

// File: rtl/sysclk_switch_div.sv
`timescale 1ns/1ps
module sysclk_switch_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] code_i,
  output logic             clk_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] code_s1_q, code_s2_q, code_act_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx, last_w, half_w;
  logic [CNT_W:0]   one_sh;
  logic             div_q, at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_s1_q <= '0;
      code_s2_q <= '0;
    end else begin
      code_s1_q <= code_i;
      code_s2_q <= code_s1_q;
    end
  end

  always_comb begin
    one_sh = (CNT_W+1)'(1) << code_act_q;
    last_w = one_sh[CNT_W-1:0] - CNT_W'(1);
    half_w = (code_act_q == '0) ? CNT_W'(1) : one_sh[CNT_W:1];
    cnt_nx = cnt_q + CNT_W'(1);
    at_end = (cnt_q == last_w);
  end

  // a new code is taken only at the end of a full divided period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      div_q      <= 1'b1;
      code_act_q <= '0;
    end else if (at_end) begin
      cnt_q      <= '0;
      div_q      <= 1'b1;
      code_act_q <= code_s2_q;
    end else begin
      cnt_q <= cnt_nx;
      div_q <= (cnt_nx < half_w);
    end
  end

  assign clk_o = (code_act_q == '0) ? clk_i : div_q;

  a_r3_code_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_end |=> $stable(code_act_q));
endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch
  import sysclk_switch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_clk_i,
  input  logic              pll_clk_i,
  input  logic              ext_clk_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clk_o,
  output logic [DIV_W-1:0]  adiv_code_o
);
  logic [N_SRC-1:0] want, en, src_clk;
  logic [DIV_W-1:0] div_code;
  logic             mux_clk;

  assign src_clk = {ext_clk_i, pll_clk_i, osc_clk_i};

  sysclk_switch_regs #(.N(N_SRC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .en_i       (en),
    .want_o     (want),
    .div_code_o (div_code),
    .adiv_code_o(adiv_code_o)
  );

  sysclk_switch_mux #(.N(N_SRC), .SYNC_STAGES(2)) u_mux (
    .src_clk_i(src_clk),
    .rst_ni   (rst_ni),
    .want_i   (want),
    .en_o     (en),
    .clk_o    (mux_clk)
  );

  sysclk_switch_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (mux_clk),
    .rst_ni(rst_ni),
    .code_i(div_code),
    .clk_o (clk_o)
  );

  a_r4_one_source_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en));
endmodule

// File: tb/sysclk_switch_tb.sv
`timescale 1ns/1ps
module sysclk_switch_tb_top;
  logic        clk = 1'b0, osc = 1'b0, pll = 1'b0, ext = 1'b0;
  logic        rst_n = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        clk_out;
  logic [2:0]  adiv;

  int checks = 0, failures = 0;

  always #10    clk = ~clk;
  always #31.25 osc = ~osc;
  always #6.25  pll = ~pll;
  always #50    ext = ~ext;

  sysclk_switch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .osc_clk_i(osc), .pll_clk_i(pll), .ext_clk_i(ext),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .clk_o(clk_out), .adiv_code_o(adiv)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  // scoreboard of expected output periods
  real   exp_q[$];
  string tag_q[$];
  int    pushed = 0, seen = 0;

  task automatic expect_period(real p, string req);
    exp_q.push_back(p); tag_q.push_back(req); pushed++;
    wait (seen == pushed);
  endtask

  initial begin
    forever begin
      real t0, per, e;
      string req;
      wait (exp_q.size() > 0);
      @(posedge clk_out); t0 = $realtime;
      repeat (4) @(posedge clk_out);
      per = ($realtime - t0) / 4.0;
      e = exp_q.pop_front(); req = tag_q.pop_front();
      checks++;
      if (per < e * 0.99 - 0.1 || per > e * 1.01 + 0.1) begin
        failures++;
        $display("FAIL %s period actual=%0.3f expected=%0.3f", req, per, e);
      end
      seen++;
    end
  end

  // pulse-width monitor for R4
  real last_t = 0.0, min_pulse = 1.0e9;
  bit  armed = 1'b0;
  always @(clk_out) begin
    if (armed && ($realtime - last_t) < min_pulse) min_pulse = $realtime - last_t;
    last_t = $realtime;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    #100 rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); chk("R1 misc reset", v, 16'h0041);
    rd(2'd1, v); chk("R1 div reset", v, 16'h0200);
    rd(2'd2, v); chk("R1 status reset", v, 16'h0000);
    chk("R8 adiv reset", adiv, 3'd2);
    #300 armed = 1'b1;
    expect_period(12.5, "R1 pll undivided");

    // R3 divide codes
    wr(2'd1, 16'h0203); #1000;
    expect_period(100.0, "R3 code 3");
    chk("R8 adiv unchanged", adiv, 3'd2);
    wr(2'd1, 16'hF507); #2000;
    rd(2'd1, v); chk("R8 div readback", v, 16'h0507);
    chk("R8 adiv out", adiv, 3'd5);
    expect_period(1600.0, "R3 code 7");
    wr(2'd1, 16'h0200); #3500;
    expect_period(12.5, "R3 code 0");

    // R5/R7 switch to oscillator, second write while busy
    wr(2'd0, 16'h0040);
    wr(2'd0, 16'h0042);
    rd(2'd2, v); chk("R5 busy after write", v, 16'h0001);
    #2000;
    rd(2'd2, v); chk("R5 busy cleared", v, 16'h0000);
    rd(2'd0, v); chk("R7 write while busy ignored", v, 16'h0040);
    expect_period(62.5, "R2 oscillator");

    // R6 same code
    wr(2'd0, 16'h0040);
    rd(2'd2, v); chk("R6 same code no busy", v, 16'h0000);
    expect_period(62.5, "R6 period unchanged");

    // R7 reserved code
    wr(2'd0, 16'h0043);
    rd(2'd0, v); chk("R7 reserved ignored", v, 16'h0040);
    rd(2'd2, v); chk("R7 reserved no busy", v, 16'h0000);

    // R2 external source
    wr(2'd0, 16'h0042); #2000;
    rd(2'd0, v); chk("R2 ext selected", v, 16'h0042);
    expect_period(100.0, "R2 external");

    // R3 divided, then R2/R4 switch while divided
    wr(2'd1, 16'h0201); #1500;
    expect_period(200.0, "R3 code 1 on ext");
    wr(2'd0, 16'h0041); #2000;
    rd(2'd2, v); chk("R5 busy cleared pll", v, 16'h0000);
    expect_period(25.0, "R2 pll divided by 2");

    // R4 no short pulses anywhere in the run
    checks++;
    if (min_pulse < 6.2) begin
      failures++;
      $display("FAIL R4 min pulse actual=%0.3f expected>=6.25", min_pulse);
    end
    finish_run();
  end
endmodule